// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox Bridge

This block sits on an 8-bit I/O-mapped expansion card and links a host processor to a coprocessor on the card. The host reaches it through two adjacent I/O ports. The base of the pair is set by a 4-bit switch value. The lower port carries mailbox bytes. The upper port is control when written and status when read. Two one-byte latches, each with its own pending flag, carry bytes in the two directions. The flag of the host-to-card latch is the coprocessor's fast-interrupt request.

Writing the control port can also freeze the coprocessor. While it is frozen, the coprocessor's reset is asserted. The data port then stops feeding the mailbox and instead streams bytes into the first 256-byte block of card RAM, through an 8-bit pointer that steps up by one after each byte. On the card side there is one mailbox address, reached through plain read and write strobes. A read there takes the host's byte. A write there posts a byte for the host.

Top module: `mbx_bridge`

## Requirements
- R1: The port pair sits at base = switch × 0x40 + 0x10. The mailbox port is at base and the control/status port at base+1. `host_sel_o` is high exactly when the address matches one of the two.
- R2: Switch values 0–3 and 15 are invalid. With an invalid switch value the block never selects, and host writes and reads have no effect.
- R3: A host read of the mailbox port returns the card-to-host byte and clears that latch's pending flag.
- R4: A host read of the status port returns 0x00 while a card-to-host byte is pending and 0x02 otherwise, and changes no state.
- R5: A host write to the control port sets freeze to the inverse of data bit 0, clears the host-to-card pending flag and reloads the RAM pointer with 0xFF. `cop_reset_o` shows freeze from the next cycle.
- R6: A host write to the mailbox port while frozen produces a RAM write one cycle later, at the current pointer, with that byte. The pointer then steps by one and wraps from 0xFF to 0x00. The host-to-card latch is untouched.
- R7: A host write to the mailbox port while not frozen loads the host-to-card latch and sets its pending flag. `cop_firq_o` shows that flag from the next cycle.
- R8: `cop_rdata_o` shows the host-to-card byte. A card read strobe clears its pending flag. A card write strobe loads the card-to-host latch and sets its pending flag.
- R9: After reset the coprocessor is frozen, the RAM pointer is 0xFF and both pending flags are clear.
- R10: Writing a latch whose flag is already set replaces the byte and leaves the flag set.
- R11: When a latch is loaded and taken in the same cycle, the load wins. The reader gets the old byte and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_i | input | 4 | Base-select switch value |
| host_addr_i | input | 10 | Host I/O address |
| host_rd_i | input | 1 | Host read strobe, one cycle |
| host_wr_i | input | 1 | Host write strobe, one cycle |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte for the addressed port |
| host_sel_o | output | 1 | Address hits one of the two ports |
| cop_rd_i | input | 1 | Card-side mailbox read strobe |
| cop_wr_i | input | 1 | Card-side mailbox write strobe |
| cop_wdata_i | input | 8 | Card-side write byte |
| cop_rdata_o | output | 8 | Host-to-card byte |
| cop_reset_o | output | 1 | Coprocessor held in reset |
| cop_firq_o | output | 1 | Fast-interrupt request (host byte pending) |
| ram_we_o | output | 1 | Card RAM write enable |
| ram_addr_o | output | 8 | Card RAM byte address within the first block |
| ram_wdata_o | output | 8 | Card RAM write byte |

## Verification
The bench sweeps all switch values against the whole address space. A decoder with a wrong stride or offset, or with a wrong valid range, shows up there as stray or missing selects. It streams 257 bytes while the coprocessor is frozen. This catches a pointer that starts at 0x00, writes after stepping, or fails to wrap. It also drives a load and a take into the same cycle on each latch, where a design with clear-over-set priority would lose a byte. It checks that a control write drops a pending interrupt and reloads the pointer, and that an invalid switch value leaves the reset line alone.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned PTR_W  = 8;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t STAT_PENDING = 8'h00;
    localparam byte_t STAT_EMPTY   = 8'h02;

    typedef struct packed {
        logic              frozen;
        logic [PTR_W-1:0]  ptr;
        logic              ram_we;
        logic [PTR_W-1:0]  ram_addr;
        byte_t             ram_wdata;
    } ctl_t;
endpackage

// File: rtl/mbx_addr_dec.sv
`timescale 1ns/1ps
module mbx_addr_dec #(
    parameter int unsigned SW_W   = 4,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned STRIDE = 64,
    parameter int unsigned OFFSET = 16,
    parameter int unsigned SW_MIN = 4,
    parameter int unsigned SW_MAX = 14
) (
    input  logic [SW_W-1:0]   sw_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_data_o,
    output logic              hit_ctl_o
);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
    localparam logic [ADDR_W-1:0] OFFSET_V = ADDR_W'(OFFSET);
    localparam logic [SW_W-1:0]   MIN_V    = SW_W'(SW_MIN);
    localparam logic [SW_W-1:0]   MAX_V    = SW_W'(SW_MAX);

    logic [ADDR_W-1:0] base;
    logic              sw_ok;

    always_comb begin
        base       = ADDR_W'(sw_i) * STRIDE_V + OFFSET_V;
        sw_ok      = (sw_i >= MIN_V) && (sw_i <= MAX_V);
        hit_data_o = sw_ok && (addr_i == base);
        hit_ctl_o  = sw_ok && (addr_i == base + ADDR_W'(1));
    end
endmodule

// File: rtl/mbx_latch.sv
`timescale 1ns/1ps
module mbx_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         take_i,
    output logic [W-1:0] dout_o,
    output logic         pend_o
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take_i) begin
            slot_d.pend = 1'b0;
        end
        if (load_i) begin
            slot_d.data = din_i;
            slot_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign dout_o = slot_q.data;
    assign pend_o = slot_q.pend;
endmodule

// File: rtl/mbx_bridge.sv
`timescale 1ns/1ps
module mbx_bridge #(
    parameter int unsigned SW_W   = 4,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned STRIDE = 64,
    parameter int unsigned OFFSET = 16,
    parameter int unsigned SW_MIN = 4,
    parameter int unsigned SW_MAX = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   sw_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [7:0]        host_wdata_i,
    output logic [7:0]        host_rdata_o,
    output logic              host_sel_o,
    input  logic              cop_rd_i,
    input  logic              cop_wr_i,
    input  logic [7:0]        cop_wdata_i,
    output logic [7:0]        cop_rdata_o,
    output logic              cop_reset_o,
    output logic              cop_firq_o,
    output logic              ram_we_o,
    output logic [7:0]        ram_addr_o,
    output logic [7:0]        ram_wdata_o
);
    import mbx_pkg::*;

    logic  hit_data, hit_ctl;
    logic  hwr_data, hwr_ctl, hrd_data;
    byte_t h2c_byte, c2h_byte;
    logic  h2c_pend, c2h_pend;
    ctl_t  ctl_d, ctl_q;

    mbx_addr_dec #(
        .SW_W(SW_W), .ADDR_W(ADDR_W), .STRIDE(STRIDE),
        .OFFSET(OFFSET), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX)
    ) dec_i (
        .sw_i       (sw_i),
        .addr_i     (host_addr_i),
        .hit_data_o (hit_data),
        .hit_ctl_o  (hit_ctl)
    );

    assign hwr_data = host_wr_i && hit_data;
    assign hwr_ctl  = host_wr_i && hit_ctl;
    assign hrd_data = host_rd_i && hit_data;

    // host to card: loaded by a running-mode data write, taken by the card
    // or dropped by any control write
    mbx_latch #(.W(DATA_W)) h2c_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (hwr_data && !ctl_q.frozen),
        .din_i  (host_wdata_i),
        .take_i (cop_rd_i || hwr_ctl),
        .dout_o (h2c_byte),
        .pend_o (h2c_pend)
    );

    // card to host: loaded by the card, taken by a host data read
    mbx_latch #(.W(DATA_W)) c2h_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cop_wr_i),
        .din_i  (cop_wdata_i),
        .take_i (hrd_data),
        .dout_o (c2h_byte),
        .pend_o (c2h_pend)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ram_we = 1'b0;
        if (hwr_ctl) begin
            ctl_d.frozen = ~host_wdata_i[0];
            ctl_d.ptr    = '1;
        end else if (hwr_data && ctl_q.frozen) begin
            ctl_d.ram_we    = 1'b1;
            ctl_d.ram_addr  = ctl_q.ptr;
            ctl_d.ram_wdata = host_wdata_i;
            ctl_d.ptr       = ctl_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.frozen <= 1'b1;
            ctl_q.ptr    <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (hit_data) begin
            host_rdata_o = c2h_byte;
        end else if (hit_ctl) begin
            host_rdata_o = c2h_pend ? STAT_PENDING : STAT_EMPTY;
        end else begin
            host_rdata_o = '0;
        end
    end

    assign host_sel_o  = hit_data || hit_ctl;
    assign cop_rdata_o = h2c_byte;
    assign cop_reset_o = ctl_q.frozen;
    assign cop_firq_o  = h2c_pend;
    assign ram_we_o    = ctl_q.ram_we;
    assign ram_addr_o  = ctl_q.ram_addr;
    assign ram_wdata_o = ctl_q.ram_wdata;
endmodule

// File: rtl/mbx_bridge_chk.sv
`timescale 1ns/1ps
module mbx_bridge_chk #(
    parameter int unsigned SW_W   = 4,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned STRIDE = 64,
    parameter int unsigned OFFSET = 16,
    parameter int unsigned SW_MIN = 4,
    parameter int unsigned SW_MAX = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SW_W-1:0]   sw_i,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic              host_wr_i,
    input logic [7:0]        host_wdata_i,
    input logic              host_sel_o,
    input logic              cop_reset_o,
    input logic              cop_firq_o,
    input logic              ram_we_o,
    input logic [7:0]        ram_addr_o,
    input logic [7:0]        ram_wdata_o
);
    logic        sw_good;
    logic [31:0] where_data;
    logic        at_data, at_ctl;

    always_comb begin
        sw_good    = (int'(sw_i) >= int'(SW_MIN)) && (int'(sw_i) <= int'(SW_MAX));
        where_data = int'(sw_i) * STRIDE + OFFSET;
        at_data    = sw_good && (32'(host_addr_i) == where_data);
        at_ctl     = sw_good && (32'(host_addr_i) == where_data + 32'd1);
    end

    a_r5_freeze_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && at_ctl) |=> (cop_reset_o == !$past(host_wdata_i[0])));

    a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && at_data && !cop_reset_o) |=> cop_firq_o);

    a_r6_ram_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && at_data && cop_reset_o) |=>
            (ram_we_o && ram_wdata_o == $past(host_wdata_i)));

    a_r6_we_only_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> cop_reset_o);

    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && $past(ram_we_o)) |-> (ram_addr_o == $past(ram_addr_o) + 8'd1));

    a_r2_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_good |-> !host_sel_o);

    a_r2_reset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_good && host_wr_i) |=> ($stable(cop_reset_o) && !ram_we_o));
endmodule

bind mbx_bridge mbx_bridge_chk #(
    .SW_W(SW_W), .ADDR_W(ADDR_W), .STRIDE(STRIDE),
    .OFFSET(OFFSET), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_i         (sw_i),
    .host_addr_i  (host_addr_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .host_sel_o   (host_sel_o),
    .cop_reset_o  (cop_reset_o),
    .cop_firq_o   (cop_firq_o),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_wdata_o  (ram_wdata_o)
);

// File: tb/mbx_bridge_tb_top.sv
`timescale 1ns/1ps
module mbx_bridge_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw = 4'd8;
    logic [9:0] haddr = '0;
    logic       hrd = 1'b0, hwr = 1'b0;
    logic [7:0] hwdata = '0;
    logic [7:0] hrdata;
    logic       hsel;
    logic       crd = 1'b0, cwr = 1'b0;
    logic [7:0] cwdata = '0;
    logic [7:0] crdata;
    logic       creset, cfirq, rwe;
    logic [7:0] raddr, rwdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbx_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .sw_i(sw), .host_addr_i(haddr),
        .host_rd_i(hrd), .host_wr_i(hwr), .host_wdata_i(hwdata),
        .host_rdata_o(hrdata), .host_sel_o(hsel),
        .cop_rd_i(crd), .cop_wr_i(cwr), .cop_wdata_i(cwdata),
        .cop_rdata_o(crdata), .cop_reset_o(creset), .cop_firq_o(cfirq),
        .ram_we_o(rwe), .ram_addr_o(raddr), .ram_wdata_o(rwdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic logic [9:0] base_of(input int s);
        return 10'(s * 64 + 16);
    endfunction

    task automatic hwrite(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        haddr = a; hwdata = d; hwr = 1'b1;
        @(negedge clk);
        hwr = 1'b0;
    endtask

    task automatic hread(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        haddr = a; hrd = 1'b1;
        #1 d = hrdata;
        @(negedge clk);
        hrd = 1'b0;
    endtask

    task automatic cwrite(input logic [7:0] d);
        @(negedge clk);
        cwdata = d; cwr = 1'b1;
        @(negedge clk);
        cwr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [9:0] b;

        // R1 R2: decode sweep over every switch value and address
        for (int s = 0; s < 16; s++) begin
            for (int a = 0; a < 1024; a++) begin
                bit exp_sel;
                sw = 4'(s); haddr = 10'(a);
                #1;
                exp_sel = (s >= 4 && s <= 14) && (a == s * 64 + 16 || a == s * 64 + 17);
                eq((s >= 4 && s <= 14) ? "R1 select" : "R2 select", int'(hsel), int'(exp_sel));
            end
        end

        sw = 4'd8;
        b  = base_of(8);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        eq("R9 reset held", int'(creset), 1);
        eq("R9 irq clear", int'(cfirq), 0);
        hread(b + 10'd1, rv);
        eq("R9 R4 status empty", int'(rv), 8'h02);

        // R6: frozen stream, first at 0xFF, then 0x00.. with wrap
        hwrite(b, 8'hA5);
        eq("R6 we", int'(rwe), 1);
        eq("R6 first addr", int'(raddr), 8'hFF);
        eq("R6 data", int'(rwdata), 8'hA5);
        eq("R6 mailbox untouched", int'(cfirq), 0);
        for (int i = 0; i < 257; i++) begin
            logic [7:0] dv;
            dv = 8'((i * 7 + 3) & 255);
            hwrite(b, dv);
            eq("R6 stream addr", int'(raddr), (i & 255));
            eq("R6 stream data", int'(rwdata), int'(dv));
        end
        @(negedge clk);
        eq("R6 we drops", int'(rwe), 0);

        // R5 release
        hwrite(b + 10'd1, 8'h01);
        eq("R5 released", int'(creset), 0);

        // R7 mailbox to card
        hwrite(b, 8'h3C);
        eq("R7 irq set", int'(cfirq), 1);
        eq("R7 card byte", int'(crdata), 8'h3C);
        eq("R7 no ram write", int'(rwe), 0);

        // R10 overwrite
        hwrite(b, 8'h5A);
        eq("R10 irq held", int'(cfirq), 1);
        eq("R10 new byte", int'(crdata), 8'h5A);

        // R8 card read takes it
        @(negedge clk); crd = 1'b1;
        #1 eq("R8 card read byte", int'(crdata), 8'h5A);
        @(negedge clk); crd = 1'b0;
        eq("R8 irq cleared", int'(cfirq), 0);

        // R11 host load and card take together
        @(negedge clk); haddr = b; hwdata = 8'h77; hwr = 1'b1; crd = 1'b1;
        @(negedge clk); hwr = 1'b0; crd = 1'b0;
        eq("R11 load wins", int'(cfirq), 1);
        eq("R11 byte", int'(crdata), 8'h77);

        // R5 control write in run mode drops pending
        hwrite(b + 10'd1, 8'h03);
        eq("R5 irq dropped", int'(cfirq), 0);
        eq("R5 stays running", int'(creset), 0);

        // R8 R4 R3 card to host
        cwrite(8'h99);
        hread(b + 10'd1, rv);
        eq("R4 status pending", int'(rv), 8'h00);
        hread(b + 10'd1, rv);
        eq("R4 status read no effect", int'(rv), 8'h00);
        hread(b, rv);
        eq("R3 host read byte", int'(rv), 8'h99);
        hread(b + 10'd1, rv);
        eq("R3 pending cleared", int'(rv), 8'h02);

        // R10 card side overwrite
        cwrite(8'h11);
        cwrite(8'h22);
        hread(b + 10'd1, rv);
        eq("R10 card flag held", int'(rv), 8'h00);
        hread(b, rv);
        eq("R10 card byte replaced", int'(rv), 8'h22);

        // R11 card load and host take together
        @(negedge clk); haddr = b; hrd = 1'b1; cwr = 1'b1; cwdata = 8'h44;
        #1 eq("R11 host reads old", int'(hrdata), 8'h22);
        @(negedge clk); hrd = 1'b0; cwr = 1'b0;
        hread(b + 10'd1, rv);
        eq("R11 flag set", int'(rv), 8'h00);
        hread(b, rv);
        eq("R11 new byte", int'(rv), 8'h44);

        // R5 freeze with pending irq, pointer reload
        hwrite(b, 8'h12);
        eq("R7 irq before freeze", int'(cfirq), 1);
        hwrite(b + 10'd1, 8'hFE);
        eq("R5 frozen", int'(creset), 1);
        eq("R5 irq cleared", int'(cfirq), 0);
        hwrite(b, 8'h01);
        hwrite(b, 8'h02);
        hwrite(b + 10'd1, 8'h00);
        hwrite(b, 8'h6B);
        eq("R5 pointer reloaded", int'(raddr), 8'hFF);
        eq("R5 reload data", int'(rwdata), 8'h6B);

        // R2 invalid switch values leave state alone
        hwrite(b + 10'd1, 8'h01);
        eq("R5 run again", int'(creset), 0);
        sw = 4'd2;
        hwrite(base_of(2) + 10'd1, 8'h00);
        eq("R2 sw2 reset untouched", int'(creset), 0);
        hwrite(base_of(2), 8'h55);
        eq("R2 sw2 no irq", int'(cfirq), 0);
        sw = 4'd15;
        hwrite(10'(15 * 64 + 17), 8'h00);
        eq("R2 sw15 reset untouched", int'(creset), 0);
        cwrite(8'h81);
        sw = 4'd0;
        hread(10'h010, rv);
        sw = 4'd8;
        hread(b + 10'd1, rv);
        eq("R2 invalid read no take", int'(rv), 8'h00);
        hread(b, rv);

        // R1 end points of the valid range
        sw = 4'd4;
        hwrite(base_of(4) + 10'd1, 8'h00);
        eq("R1 sw4 control", int'(creset), 1);
        hwrite(base_of(4) + 10'd1, 8'h01);
        sw = 4'd14;
        hwrite(base_of(14), 8'h66);
        eq("R1 sw14 mailbox irq", int'(cfirq), 1);
        eq("R1 sw14 byte", int'(crdata), 8'h66);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule